// File: doc/BRIEF.md
# Secured configuration store controller

This block sits between a programming port and the configuration storage of a small programmable logic device. The storage holds a fuse pattern of byte-wide words and a separate user signature of eight bytes. Commands come in one at a time over a valid/ready handshake. Each command is one of these: fuse write, fuse verify (read-back), preload of the test register, signature write, signature read, set security, or full erase. For every command the block returns a single-cycle response with an accepted/refused flag and, for reads, a data byte.

A security bit guards the fuse contents. Once the bit is set, verify reads of the fuse pattern and preload commands are refused. The signature stays readable and writable whatever the state of the bit. The lock is a register written by the command that sets it, so the command that follows already sees the locked state. Only a full erase clears the bit, and the same erase also wipes the fuse pattern. A register model stands in for the physical cells.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After rst_ni is released, the security bit is clear, every fuse word and signature byte reads 0, preload_o is 0, cmd_ready_o is 1 and rsp_valid_o is 0.
- R2: A command is taken on a clock edge where cmd_valid_i and cmd_ready_o are both 1. rsp_valid_o is 1 for exactly the following cycle. cmd_ready_o is 0 during that cycle.
- R3: Opcodes on cmd_op_i are 0 fuse write, 1 fuse verify, 2 preload, 3 signature write, 4 signature read, 5 set security, 6 full erase and 7 reserved. A fuse write stores cmd_data_i at word cmd_addr_i and is accepted whether or not the block is locked.
- R4: A fuse verify returns the stored word with rsp_ok_o=1 while unlocked. While locked it is refused with rsp_ok_o=0 and rsp_data_o=0.
- R5: A preload while unlocked is accepted and drives cmd_data_i onto preload_o. While locked it is refused and preload_o keeps its value.
- R6: The set-security command is accepted, and the command accepted right after it is already treated as locked.
- R7: A signature write or read at byte index cmd_addr_i below 8 is accepted in both lock states. A signature access at an index of 8 or above is refused.
- R8: A full erase is accepted. It clears the security bit and every fuse word to 0 and leaves the signature bytes unchanged.
- R9: A refused command changes no stored data. A refused command returns rsp_data_o=0, as does any accepted write, lock or erase. Opcode 7 is always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_op_i | input | 3 | Command opcode |
| cmd_addr_i | input | ADDR_W (4) | Fuse word address or signature byte index |
| cmd_data_i | input | DATA_W (8) | Write or preload data |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_ok_o | output | 1 | 1 accepted, 0 refused |
| rsp_data_o | output | DATA_W (8) | Read data, 0 unless an accepted read |
| preload_o | output | DATA_W (8) | Preloaded test register value |

## Verification
The fuse array is filled with a computed pattern that differs at every address. Each word is then verified, which shows that addressing is correct and not merely that some data lands somewhere. The same verify and preload commands are then sent in three states: unlocked, on the command straight after setting security, and after a full erase. Each accept/refuse result is set against the lock state alone. Signature bytes are written with distinct values and read back in both lock states and after the erase. Out-of-range indices and the reserved opcode check that refusals leave data untouched.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [2:0] {
    OP_FUSE_WR = 3'd0,
    OP_FUSE_RD = 3'd1,
    OP_PRELOAD = 3'd2,
    OP_SIG_WR  = 3'd3,
    OP_SIG_RD  = 3'd4,
    OP_LOCK    = 3'd5,
    OP_ERASE   = 3'd6,
    OP_RSVD    = 3'd7
  } cmd_op_e;
endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int SIG_BYTES = 8,
  localparam int FUSE_WORDS = 2 ** ADDR_W,
  localparam int SIG_IW     = $clog2(SIG_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_we_i,
  input  logic              sig_we_i,
  input  logic              pre_we_i,
  input  logic              lock_set_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] fuse_rdata_o,
  output logic [DATA_W-1:0] sig_rdata_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] preload_o
);
  logic [DATA_W-1:0] fuse_q [FUSE_WORDS];
  logic [DATA_W-1:0] sig_q  [SIG_BYTES];
  logic              lock_q;
  logic [DATA_W-1:0] pre_q;
  logic [SIG_IW-1:0] sig_idx;

  assign sig_idx = addr_i[SIG_IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
      lock_q <= 1'b0;
    end else if (erase_i) begin
      for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
      lock_q <= 1'b0;
    end else begin
      if (fuse_we_i) fuse_q[addr_i] <= wdata_i;
      if (lock_set_i) lock_q <= 1'b1;
    end
  end

  // signature region is never touched by erase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SIG_BYTES; i++) sig_q[i] <= '0;
    end else if (sig_we_i) begin
      sig_q[sig_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (pre_we_i) pre_q <= wdata_i;
  end

  assign fuse_rdata_o = fuse_q[addr_i];
  assign sig_rdata_o  = sig_q[sig_idx];
  assign lock_o       = lock_q;
  assign preload_o    = pre_q;

  assert_erase_unlocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (!lock_q && fuse_q[0] == '0));
endmodule

// File: rtl/cfg_gate.sv
module cfg_gate
  import cfg_guard_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int SIG_BYTES = 8
) (
  input  cmd_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fire_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] fuse_rdata_i,
  input  logic [DATA_W-1:0] sig_rdata_i,
  output logic              fuse_we_o,
  output logic              sig_we_o,
  output logic              pre_we_o,
  output logic              lock_set_o,
  output logic              erase_o,
  output logic              ok_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sig_in_range;
  assign sig_in_range = (int'(addr_i) < SIG_BYTES);

  always_comb begin
    fuse_we_o  = 1'b0;
    sig_we_o   = 1'b0;
    pre_we_o   = 1'b0;
    lock_set_o = 1'b0;
    erase_o    = 1'b0;
    ok_o       = 1'b0;
    rdata_o    = '0;
    unique case (op_i)
      OP_FUSE_WR: begin ok_o = 1'b1; fuse_we_o = fire_i; end
      OP_FUSE_RD: begin
        ok_o = !lock_i;
        if (!lock_i) rdata_o = fuse_rdata_i;
      end
      OP_PRELOAD: begin ok_o = !lock_i; pre_we_o = fire_i && !lock_i; end
      OP_SIG_WR:  begin ok_o = sig_in_range; sig_we_o = fire_i && sig_in_range; end
      OP_SIG_RD: begin
        ok_o = sig_in_range;
        if (sig_in_range) rdata_o = sig_rdata_i;
      end
      OP_LOCK:    begin ok_o = 1'b1; lock_set_o = fire_i; end
      OP_ERASE:   begin ok_o = 1'b1; erase_o = fire_i; end
      default:    ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_rsp.sv
module cfg_rsp #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              ok_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              valid_o,
  output logic              ok_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ok_o    <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        ok_o   <= ok_i;
        data_o <= rdata_i;
      end
    end
  end
endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int SIG_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [DATA_W-1:0] preload_o
);
  cmd_op_e           op;
  logic              fire, lock;
  logic              fuse_we, sig_we, pre_we, lock_set, erase, ok;
  logic [DATA_W-1:0] fuse_rdata, sig_rdata, rdata;

  assign op          = cmd_op_e'(cmd_op_i);
  assign cmd_ready_o = !rsp_valid_o;  // one command in flight
  assign fire        = cmd_valid_i && cmd_ready_o;

  cfg_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIG_BYTES(SIG_BYTES)) u_store (
    .clk_i, .rst_ni,
    .fuse_we_i(fuse_we), .sig_we_i(sig_we), .pre_we_i(pre_we),
    .lock_set_i(lock_set), .erase_i(erase),
    .addr_i(cmd_addr_i), .wdata_i(cmd_data_i),
    .fuse_rdata_o(fuse_rdata), .sig_rdata_o(sig_rdata),
    .lock_o(lock), .preload_o(preload_o)
  );

  cfg_gate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIG_BYTES(SIG_BYTES)) u_gate (
    .op_i(op), .addr_i(cmd_addr_i), .fire_i(fire), .lock_i(lock),
    .fuse_rdata_i(fuse_rdata), .sig_rdata_i(sig_rdata),
    .fuse_we_o(fuse_we), .sig_we_o(sig_we), .pre_we_o(pre_we),
    .lock_set_o(lock_set), .erase_o(erase), .ok_o(ok), .rdata_o(rdata)
  );

  cfg_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i, .rst_ni, .fire_i(fire), .ok_i(ok), .rdata_i(rdata),
    .valid_o(rsp_valid_o), .ok_o(rsp_ok_o), .data_o(rsp_data_o)
  );

  assert_rsp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (rsp_valid_o && !cmd_ready_o));
  assert_rsp_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_locked_verify_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_FUSE_RD && lock) |=> (!rsp_ok_o && rsp_data_o == '0));
  assert_locked_preload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_PRELOAD && lock) |=> (!rsp_ok_o && $stable(preload_o)));
  assert_lock_now_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_LOCK) |=> lock);
  assert_sig_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_SIG_RD && int'(cmd_addr_i) < SIG_BYTES) |=> rsp_ok_o);
  assert_rsvd_refused_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_RSVD) |=> (!rsp_ok_o && rsp_data_o == '0));
endmodule

// File: tb/cfg_guard_ctrl_test.sv
module cfg_guard_ctrl_test;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic [2:0]    cmd_op_i = '0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] cmd_data_i = '0;
  logic          rsp_valid_o, rsp_ok_o;
  logic [DW-1:0] rsp_data_o, preload_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  cfg_guard_ctrl uut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_addr_i,
    .cmd_data_i, .rsp_valid_o, .rsp_ok_o, .rsp_data_o, .preload_o
  );

  task automatic check(input bit cond, input string req, input string msg);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) & 8'hff);
  endfunction

  // monitor: pops expected responses and compares
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response, actual valid=1 expected none");
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_ok_o, rsp_data_o} == e, t,
              $sformatf("ok/data actual=%0b/%02h expected=%0b/%02h",
                        rsp_ok_o, rsp_data_o, e[DW], e[DW-1:0]));
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input int addr, input logic [DW-1:0] data,
                        input bit exp_ok, input logic [DW-1:0] exp_data, input string req);
    @(negedge clk_i);
    check(cmd_ready_o == 1'b1, "R2", $sformatf("ready before cmd actual=%0b expected=1", cmd_ready_o));
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_addr_i  = AW'(addr);
    cmd_data_i  = data;
    exp_q.push_back({exp_ok, exp_data});
    tag_q.push_back(req);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check(rsp_valid_o && !cmd_ready_o, "R2",
          $sformatf("rsp cycle valid/ready actual=%0b/%0b expected=1/0", rsp_valid_o, cmd_ready_o));
    @(negedge clk_i);
    check(!rsp_valid_o && cmd_ready_o, "R2",
          $sformatf("after rsp valid/ready actual=%0b/%0b expected=0/1", rsp_valid_o, cmd_ready_o));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cmd_ready_o && !rsp_valid_o, "R1",
          $sformatf("reset ready/valid actual=%0b/%0b expected=1/0", cmd_ready_o, rsp_valid_o));
    check(preload_o == '0, "R1", $sformatf("reset preload actual=%02h expected=00", preload_o));
    do_cmd(3'd1, 3, 8'h00, 1'b1, 8'h00, "R1");
    do_cmd(3'd4, 5, 8'h00, 1'b1, 8'h00, "R1");

    // program and verify full fuse array
    for (int i = 0; i < 2 ** AW; i++) do_cmd(3'd0, i, pat(i), 1'b1, 8'h00, "R3");
    for (int i = 0; i < 2 ** AW; i++) do_cmd(3'd1, i, 8'h00, 1'b1, pat(i), "R4");

    do_cmd(3'd2, 0, 8'hA5, 1'b1, 8'h00, "R5");
    check(preload_o == 8'hA5, "R5", $sformatf("preload actual=%02h expected=a5", preload_o));

    for (int i = 0; i < 8; i++) do_cmd(3'd3, i, 8'hC0 + 8'(i), 1'b1, 8'h00, "R7");
    for (int i = 0; i < 8; i++) do_cmd(3'd4, i, 8'h00, 1'b1, 8'hC0 + 8'(i), "R7");
    do_cmd(3'd3, 9, 8'h77, 1'b0, 8'h00, "R7");
    do_cmd(3'd4, 1, 8'h00, 1'b1, 8'hC1, "R9");   // refused write at 9 left byte 1 alone
    do_cmd(3'd4, 12, 8'h00, 1'b0, 8'h00, "R7");
    do_cmd(3'd7, 2, 8'h55, 1'b0, 8'h00, "R9");
    do_cmd(3'd1, 2, 8'h00, 1'b1, pat(2), "R9");

    // lock; next command already locked
    do_cmd(3'd5, 0, 8'h00, 1'b1, 8'h00, "R6");
    do_cmd(3'd1, 4, 8'h00, 1'b0, 8'h00, "R6");
    do_cmd(3'd1, 7, 8'h00, 1'b0, 8'h00, "R4");
    do_cmd(3'd2, 0, 8'h3C, 1'b0, 8'h00, "R5");
    check(preload_o == 8'hA5, "R5", $sformatf("locked preload actual=%02h expected=a5", preload_o));
    do_cmd(3'd4, 6, 8'h00, 1'b1, 8'hC6, "R7");
    do_cmd(3'd3, 6, 8'h99, 1'b1, 8'h00, "R7");
    do_cmd(3'd4, 6, 8'h00, 1'b1, 8'h99, "R7");
    do_cmd(3'd0, 1, 8'hEE, 1'b1, 8'h00, "R3");

    // erase restores access, signature survives
    do_cmd(3'd6, 0, 8'h00, 1'b1, 8'h00, "R8");
    do_cmd(3'd1, 1, 8'h00, 1'b1, 8'h00, "R8");
    do_cmd(3'd1, 9, 8'h00, 1'b1, 8'h00, "R8");
    do_cmd(3'd4, 6, 8'h00, 1'b1, 8'h99, "R8");
    do_cmd(3'd4, 0, 8'h00, 1'b1, 8'hC0, "R8");
    do_cmd(3'd2, 0, 8'h3C, 1'b1, 8'h00, "R8");
    check(preload_o == 8'h3C, "R8", $sformatf("preload after erase actual=%02h expected=3c", preload_o));
    do_cmd(3'd0, 5, 8'h5A, 1'b1, 8'h00, "R3");
    do_cmd(3'd1, 5, 8'h00, 1'b1, 8'h5A, "R4");

    check(exp_q.size() == 0, "R2", $sformatf("pending responses actual=%0d expected=0", exp_q.size()));
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      check(1'b0, "R2", "watchdog expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule